// File: doc/BRIEF.md
# One-Bit Correlator with Lag Search

This block estimates the delay between two binary sample streams, A and B. Each stream has already been reduced to one bit per sample by a hard limiter upstream. On every sample strobe, one new bit from each channel enters its own N-bit history register. The block then spends N system-clock cycles sweeping every candidate lag. At each lag it scores how many bit positions of the A history agree with a rotated copy of the B history.

The block keeps the highest score seen during the sweep and the lag at which that score occurred. A one-cycle done pulse marks the end of the sweep. The best lag is the delay estimate in sample periods. The peak score, from 0 up to N, tells the consumer how much to trust that estimate. The strobe runs at a much lower rate than the system clock, and consecutive strobes are at least N+2 system clocks apart.

Top module: `olc_corr_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, best_lag, peak and done are all 0, and both history registers and the working word are all zeros.
- R2: Each smp_vld cycle shifts a_bit into bit 0 of the A history and b_bit into bit 0 of the B history. Older bits move up one position, and the bit in position N-1 is discarded. Bit i therefore holds the sample taken i strobes ago.
- R3: The clock edge that samples smp_vld high sets peak and best_lag to 0 and restarts the lag counter at 0. The working word is loaded with the updated B history at the same edge.
- R4: The score at lag k is N minus the number of positions i where A history bit i differs from B history bit (i-k) mod N, that is, B rotated toward higher bit positions by k.
- R5: Lag k is scored at the (k+1)-th edge after the strobe edge. A score replaces peak, and k replaces best_lag, only when the score is strictly greater than peak. Equal scores therefore keep the lowest lag.
- R6: done is high for exactly one cycle, which begins at the N-th edge after the strobe edge, once lag N-1 has been scored.
- R7: After the sweep ends, peak and best_lag hold their values until the next smp_vld.
- R8: If both streams are periodic with period N and B equals A delayed by d samples (0 ≤ d < N), and the pattern has no shorter period, the sweep ends with best_lag = d and peak = N.
- R9: If no lag gives any agreeing bit, the sweep ends with peak = 0 and best_lag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | One-cycle sample strobe |
| a_bit | input | 1 | Channel A sample, used when smp_vld is high |
| b_bit | input | 1 | Channel B sample, used when smp_vld is high |
| best_lag | output | $clog2(N) | Lag, in sample periods, with the highest score |
| peak | output | $clog2(N+1) | Highest score found in the current sweep |
| done | output | 1 | One-cycle pulse when the sweep has finished |

## Verification
A history register that is corrupted or shifts the wrong way stays inside the block, but it changes the score at every lag. It therefore shows up as a wrong peak or best_lag within N cycles of the next strobe. A working word that rotates the wrong way, or an update that accepts ties, moves best_lag during the very first sweep in which two lags compete. A lag counter that is off by one shifts the done pulse by a cycle, and the per-cycle comparison against the reference model catches that on the first sweep.

// File: rtl/olc_pkg.sv
package olc_pkg;
  typedef enum logic [0:0] {
    SW_IDLE  = 1'b0,
    SW_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/olc_hist_reg.sv
module olc_hist_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[N-2:0], din};
    end
  end
endmodule

// File: rtl/olc_rot_word.sv
module olc_rot_word #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         rot_en,
  output logic [N-1:0] q
);
  // One step toward higher bit positions; the top bit wraps to bit 0.
  function automatic logic [N-1:0] rot_up1(input logic [N-1:0] w);
    return {w[N-2:0], w[N-1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (rot_en) begin
      q <= rot_up1(q);
    end
  end
endmodule

// File: rtl/olc_score.sv
module olc_score #(
  parameter int N  = 32,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]  a_word,
  input  logic [N-1:0]  b_word,
  output logic [SW-1:0] score
);
  function automatic int unsigned ones_in(input logic [N-1:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < N; i++) begin
      c = c + int'(v[i]);
    end
    return c;
  endfunction

  function automatic logic [SW-1:0] agree_score(input logic [N-1:0] x,
                                                input logic [N-1:0] y);
    int unsigned diff;
    diff = ones_in(x ^ y);
    return SW'(N - int'(diff));
  endfunction

  assign score = agree_score(a_word, b_word);
endmodule

// File: rtl/olc_sweep_ctrl.sv
module olc_sweep_ctrl #(
  parameter int N  = 32,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          step,
  output logic [LW-1:0] lag,
  output logic          done
);
  import olc_pkg::*;

  localparam logic [LW-1:0] LAST_LAG = LW'(N - 1);

  sweep_state_e st;
  logic [LW-1:0] cnt;

  assign step = (st == SW_SWEEP) && !start;
  assign lag  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SW_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st  <= SW_SWEEP;
        cnt <= '0;
      end else if (st == SW_SWEEP) begin
        if (cnt == LAST_LAG) begin
          st   <= SW_IDLE;
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/olc_peak_track.sv
module olc_peak_track #(
  parameter int SW = 6,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [SW-1:0] score,
  input  logic [LW-1:0] lag,
  output logic          better,
  output logic [SW-1:0] peak,
  output logic [LW-1:0] best
);
  function automatic logic beats(input logic [SW-1:0] cand,
                                 input logic [SW-1:0] held);
    return cand > held;
  endfunction

  assign better = en && beats(score, peak);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak <= '0;
      best <= '0;
    end else if (clear) begin
      peak <= '0;
      best <= '0;
    end else if (better) begin
      peak <= score;
      best <= lag;
    end
  end
endmodule

// File: rtl/olc_corr_top.sv
module olc_corr_top #(
  parameter int N  = 32,
  parameter int LW = (N > 1) ? $clog2(N) : 1,
  parameter int SW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          a_bit,
  input  logic          b_bit,
  output logic [LW-1:0] best_lag,
  output logic [SW-1:0] peak,
  output logic          done
);
  localparam int NCH = 2;

  logic [NCH-1:0]        ch_bit;
  logic [NCH-1:0][N-1:0] hist;
  logic [N-1:0]          b_after;
  logic [N-1:0]          b_work;
  logic [SW-1:0]         score;
  logic [LW-1:0]         lag_cnt;
  logic                  sweep_step;
  logic                  better;

  function automatic logic [N-1:0] push_in(input logic [N-1:0] h, input logic b);
    return {h[N-2:0], b};
  endfunction

  assign ch_bit = {b_bit, a_bit};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hist
    olc_hist_reg #(.N(N)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (smp_vld),
      .din      (ch_bit[ch]),
      .q        (hist[ch])
    );
  end

  assign b_after = push_in(hist[1], b_bit);

  olc_rot_word #(.N(N)) u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (smp_vld),
    .load_val (b_after),
    .rot_en   (sweep_step),
    .q        (b_work)
  );

  olc_score #(.N(N), .SW(SW)) u_score (
    .a_word (hist[0]),
    .b_word (b_work),
    .score  (score)
  );

  olc_sweep_ctrl #(.N(N), .LW(LW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (smp_vld),
    .step  (sweep_step),
    .lag   (lag_cnt),
    .done  (done)
  );

  olc_peak_track #(.SW(SW), .LW(LW)) u_peak (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (smp_vld),
    .en     (sweep_step),
    .score  (score),
    .lag    (lag_cnt),
    .better (better),
    .peak   (peak),
    .best   (best_lag)
  );
endmodule

// File: rtl/olc_corr_chk.sv
module olc_corr_chk #(
  parameter int N  = 32,
  parameter int LW = (N > 1) ? $clog2(N) : 1,
  parameter int SW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          sweep_step,
  input logic          better,
  input logic [SW-1:0] score,
  input logic [SW-1:0] peak,
  input logic [LW-1:0] best_lag,
  input logic          done
);
  p_clear_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (peak == '0) && (best_lag == '0));

  p_score_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    score <= SW'(N));

  p_peak_nondecr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_step && !smp_vld) |=> peak >= $past(peak));

  p_tie_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_step && !better) |=> $stable(peak) && $stable(best_lag));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sweep_step);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweep_step && !smp_vld) |=> $stable(peak) && $stable(best_lag));
endmodule

bind olc_corr_top olc_corr_chk #(.N(N), .LW(LW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld    (smp_vld),
  .sweep_step (sweep_step),
  .better     (better),
  .score      (score),
  .peak       (peak),
  .best_lag   (best_lag),
  .done       (done)
);

// File: tb/tb_olc_corr_top.sv
module tb_olc_corr_top;
  localparam int N  = 32;
  localparam int LW = $clog2(N);
  localparam int SW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic          a_bit = 1'b0;
  logic          b_bit = 1'b0;
  logic [LW-1:0] best_lag;
  logic [SW-1:0] peak;
  logic          done;

  olc_corr_top #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .a_bit(a_bit), .b_bit(b_bit),
    .best_lag(best_lag), .peak(peak), .done(done)
  );

  always #4 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  reported = 0;
  bit  cmp_on = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Behavioural reference: queues of past samples, newest first.
  int  qa[$];
  int  qb[$];
  bit  m_busy;
  int  m_k, m_peak, m_best;
  bit  m_done;

  function automatic int lag_score(int k);
    int miss = 0;
    for (int i = 0; i < N; i++) begin
      if (qa[i] != qb[((i - k) % N + N) % N]) miss++;
    end
    return N - miss;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qa = {}; qb = {};
      for (int i = 0; i < N; i++) begin qa.push_back(0); qb.push_back(0); end
      m_busy = 0; m_k = 0; m_peak = 0; m_best = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (smp_vld) begin
        qa.push_front(int'(a_bit)); void'(qa.pop_back());
        qb.push_front(int'(b_bit)); void'(qb.pop_back());
        m_busy = 1; m_k = 0; m_peak = 0; m_best = 0;
      end else if (m_busy) begin
        int x;
        x = lag_score(m_k);
        if (x > m_peak) begin m_peak = x; m_best = m_k; end
        m_k++;
        if (m_k == N) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  // Every-cycle comparison against the model (R4, R5, R6).
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(done == m_done, "R6", "done per cycle", int'(done), int'(m_done));
      check(int'(peak) == m_peak, "R4", "peak per cycle", int'(peak), m_peak);
      check(int'(best_lag) == m_best, "R5", "best_lag per cycle",
            int'(best_lag), m_best);
    end
  end

  task automatic strobe(input bit a, input bit b, input int gap);
    @(negedge clk);
    smp_vld = 1'b1; a_bit = a; b_bit = b;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [N-1:0] pat;
    int d, cyc, held_p, held_b;
    pat = 32'h1D3A_B0C7;

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(peak == 0 && best_lag == 0 && done == 0, "R1", "reset outputs",
          int'(peak) + int'(best_lag) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(peak == 0 && best_lag == 0 && done == 0, "R1", "after reset",
          int'(peak) + int'(best_lag) + int'(done), 0);
    cmp_on = 1;

    // R1: zero histories give full agreement at lag 0
    strobe(0, 0, N + 2);
    check(int'(peak) == N && best_lag == 0, "R1", "zero history peak",
          int'(peak), N);

    // R5 tie: all ones on both, every lag scores N, lowest lag kept
    for (int t = 0; t < N; t++) strobe(1, 1, N + 2);
    check(int'(peak) == N, "R5", "all-ones peak", int'(peak), N);
    check(best_lag == 0, "R5", "tie keeps lag 0", int'(best_lag), 0);

    // R9: A all ones, B all zeros, no agreement anywhere
    for (int t = 0; t < N; t++) strobe(1, 0, N + 2);
    check(peak == 0, "R9", "no-agreement peak", int'(peak), 0);
    check(best_lag == 0, "R9", "no-agreement lag", int'(best_lag), 0);

    // R2: N zero samples flush out every older one
    for (int t = 0; t < N; t++) strobe(0, 0, N + 2);
    check(int'(peak) == N && best_lag == 0, "R2", "old bits discarded",
          int'(peak), N);

    // R2 and R4: A pulse three strobes before B pulse -> match at lag 3
    strobe(1, 0, N + 2);
    strobe(0, 0, N + 2);
    strobe(0, 0, N + 2);
    strobe(0, 1, N + 2);
    check(best_lag == 3, "R2", "shift direction lag", int'(best_lag), 3);
    check(int'(peak) == N, "R4", "pulse match score", int'(peak), N);

    // R7: hold through a long idle gap
    held_p = int'(peak); held_b = int'(best_lag);
    repeat (20) @(negedge clk);
    check(int'(peak) == held_p, "R7", "peak held idle", int'(peak), held_p);
    check(int'(best_lag) == held_b, "R7", "lag held idle", int'(best_lag), held_b);

    // R3 and R6: clear right after strobe, done at the N-th edge
    @(negedge clk);
    smp_vld = 1'b1; a_bit = 1'b0; b_bit = 1'b0;
    @(negedge clk);
    smp_vld = 1'b0;
    check(peak == 0 && best_lag == 0, "R3", "cleared by strobe",
          int'(peak) + int'(best_lag), 0);
    cyc = 1;
    while (!done && cyc < 4 * N) begin @(negedge clk); cyc++; end
    check(cyc == N + 1, "R6", "done latency", cyc, N + 1);
    @(negedge clk);
    check(done == 0, "R6", "done one cycle", int'(done), 0);
    repeat (2) @(negedge clk);

    // R8: periodic pattern with B delayed by d
    for (int r = 0; r < 2; r++) begin
      d = (r == 0) ? 5 : 19;
      for (int t = 0; t < 2 * N; t++)
        strobe(pat[t % N], pat[(t - d + 4 * N) % N], N + 2);
      check(int'(best_lag) == d, "R8", "delay estimate", int'(best_lag), d);
      check(int'(peak) == N, "R8", "delay peak", int'(peak), N);
    end

    // Random streams with varied strobe spacing (R4, R5 via per-cycle model)
    for (int t = 0; t < 150; t++)
      strobe(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             N + 1 + int'($urandom_range(0, 5)));

    repeat (4) @(negedge clk);
    report();
  end
endmodule